// File: doc/BRIEF.md
# Adaptive Miss Fetch-Size Selector

This block sits beside a level-one data cache built from 8-byte physical lines. For every miss it decides whether to fetch just that line or the whole aligned 32-byte virtual line (four physical lines) that contains it. The decision is learned at run time. A small direct-mapped detection table remembers recently fetched virtual lines: how big the fetch was, which sub-line caused it, and which sub-lines have been touched since. A direct-mapped array of saturating counters, one per 1024-byte region, accumulates evidence of spatial reuse. The top bit of a region's counter selects the size of the next miss in that region.

Each access is presented as a one-cycle strobe with its byte address and the cache's hit/miss verdict. One cycle later the block returns the fetch size for a miss, and a pulse saying whether a region counter was raised or lowered, along with the index of that counter. The detection table and the counters update on the same edge, so back-to-back accesses see each other's effects without stalls.

Top module: `slt_fetch_sel`

## Requirements
- R1: After reset every output is low, every region counter is zero and the detection table holds no valid entry.
- R2: `fetch_vld` is high for exactly the cycle after a strobe whose `acc_hit` is 0. It stays low after a strobe with `acc_hit` 1 and after idle cycles.
- R3: A cache miss that hits a detection entry whose fetch was a single line, on a sub-line (address bits 4:3) other than the one that caused that fetch, sets the entry's reuse bit. If the reuse bit was clear, it also pulses `sctr_inc` and raises the region counter by one.
- R4: For an entry whose fetch was a whole virtual line, the access that brings its count of distinct touched sub-lines to three (the count saturates at 3) pulses `sctr_inc` and sets the reuse bit, whether the cache hits or misses. Each entry raises its counter at most once in its lifetime.
- R5: With a miss, `fetch_big` (1 = 32 bytes, 0 = 8 bytes) equals the most significant bit of the region counter as it stood before this access's own update. The detection index is address bits 8:5. The counter index is address bits 15:10.
- R6: A strobe that misses both the cache and the detection table replaces the indexed entry. The new entry records the chosen size and the causing sub-line, one touched sub-line, and a clear reuse bit.
- R7: When R6 replaces a valid entry whose reuse bit is clear, `sctr_dec` pulses and the counter of the evicted entry's region is lowered by one.
- R8: Region counters saturate at 0 and at 2^SCTR_W-1. With the default SCTR_W = 4, eight net raises from zero make the next miss large.
- R9: A strobe that hits the cache but misses the detection table neither allocates an entry nor produces any event.
- R10: When `sctr_inc` or `sctr_dec` is high, `sctr_region` gives the index of the counter that was changed. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| acc_hit | input | 1 | Cache verdict: 1 hit, 0 miss |
| fetch_vld | output | 1 | A fetch decision is presented |
| fetch_big | output | 1 | 1: fetch 32 bytes, 0: fetch 8 bytes |
| sctr_inc | output | 1 | A region counter was raised |
| sctr_dec | output | 1 | A region counter was lowered |
| sctr_region | output | RC_IW (6) | Index of the counter raised or lowered |

## Verification
Two functions can fall in the same cycle: reading a region counter to pick the fetch size, and writing that same counter because of a reuse detection or an eviction. Regions 64 apart share a counter, and virtual lines 16 apart in one region share a table entry. So a miss can evict an unused entry whose counter is the one being read for its own decision, and a neighbour miss can raise the counter it reads. Directed ping-pong sequences and a pseudo-random sweep over aliasing addresses provoke both cases. Every output is judged against a bench model that always takes the decision from the counter value before the update.

// File: rtl/slt_pkg.sv
package slt_pkg;
   localparam int LINE_LG  = 3;   // 8-byte physical line
   localparam int VLINE_LG = 5;   // 32-byte virtual line
   localparam int SUB_W    = VLINE_LG - LINE_LG;
   localparam int SUBS     = 1 << SUB_W;
   localparam int VC_W     = 2;
   localparam logic [VC_W-1:0] VC_FULL = '1;

   typedef enum logic {
      FETCH_LINE  = 1'b0,
      FETCH_VLINE = 1'b1
   } fsize_e;
endpackage

// File: rtl/slt_dtab.sv
module slt_dtab
   import slt_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IW    = 4,
   parameter int TAG_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_sz,
   output logic [VC_W-1:0]  rd_vc,
   output logic [SUBS-1:0]  rd_mask,
   output logic             rd_sr,
   output logic [SUB_W-1:0] rd_fi,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_sz,
   input  logic [VC_W-1:0]  wr_vc,
   input  logic [SUBS-1:0]  wr_mask,
   input  logic             wr_sr,
   input  logic [SUB_W-1:0] wr_fi
);
   if (DEPTH != (1 << IW)) begin : g_bad_depth
      $error("slt_dtab: DEPTH must equal 2**IW");
   end

   logic             valid_q [DEPTH];
   logic [TAG_W-1:0] tag_q   [DEPTH];
   logic             sz_q    [DEPTH];
   logic [VC_W-1:0]  vc_q    [DEPTH];
   logic [SUBS-1:0]  mask_q  [DEPTH];
   logic             sr_q    [DEPTH];
   logic [SUB_W-1:0] fi_q    [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            valid_q[i] <= 1'b0;
            tag_q[i]   <= '0;
            sz_q[i]    <= 1'b0;
            vc_q[i]    <= '0;
            mask_q[i]  <= '0;
            sr_q[i]    <= 1'b0;
            fi_q[i]    <= '0;
         end
      end else if (wr_en) begin
         valid_q[idx] <= 1'b1;
         tag_q[idx]   <= wr_tag;
         sz_q[idx]    <= wr_sz;
         vc_q[idx]    <= wr_vc;
         mask_q[idx]  <= wr_mask;
         sr_q[idx]    <= wr_sr;
         fi_q[idx]    <= wr_fi;
      end
   end

   assign rd_valid = valid_q[idx];
   assign rd_tag   = tag_q[idx];
   assign rd_sz    = sz_q[idx];
   assign rd_vc    = vc_q[idx];
   assign rd_mask  = mask_q[idx];
   assign rd_sr    = sr_q[idx];
   assign rd_fi    = fi_q[idx];

   // R4: the stored touch count follows the distinct sub-lines recorded, capped at 3
   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      a_r4_vc_tracks_mask: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q[g] |-> ((mask_q[g] == '1) ? (vc_q[g] == VC_FULL)
                                           : (32'(vc_q[g]) == $countones(mask_q[g]))));
      // R6: a live entry always contains the sub-line that caused its fetch
      a_r6_fi_touched: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q[g] |-> mask_q[g][fi_q[g]]);
   end
endmodule

// File: rtl/slt_rctr.sv
module slt_rctr #(
   parameter int DEPTH = 64,
   parameter int IW    = 6,
   parameter int W     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_msb,
   input  logic          inc_en,
   input  logic          dec_en,
   input  logic [IW-1:0] upd_idx
);
   if (DEPTH != (1 << IW)) begin : g_bad_depth
      $error("slt_rctr: DEPTH must equal 2**IW");
   end
   if (!(W == 1 || W == 4)) begin : g_bad_width
      $error("slt_rctr: counter width must be 1 or 4");
   end

   // R10: raise and lower requests never coincide
   a_r10_inc_dec_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc_en && dec_en));

   if (W == 1) begin : g_flag
      logic bit_q [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bit_q[i] <= 1'b0;
         end else if (inc_en) begin
            bit_q[upd_idx] <= 1'b1;
         end else if (dec_en) begin
            bit_q[upd_idx] <= 1'b0;
         end
      end
      assign rd_msb = bit_q[rd_idx];
   end else begin : g_sat
      localparam logic [W-1:0] CMAX = '1;
      logic [W-1:0] cnt_q [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
         end else if (inc_en && cnt_q[upd_idx] != CMAX) begin
            cnt_q[upd_idx] <= cnt_q[upd_idx] + 1'b1;
         end else if (dec_en && cnt_q[upd_idx] != '0) begin
            cnt_q[upd_idx] <= cnt_q[upd_idx] - 1'b1;
         end
      end
      assign rd_msb = cnt_q[rd_idx][W-1];

      a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_en && cnt_q[upd_idx] == '0) |=> (cnt_q[$past(upd_idx)] == '0));
      a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_en && cnt_q[upd_idx] == CMAX) |=> (cnt_q[$past(upd_idx)] == CMAX));
      a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_en && cnt_q[upd_idx] != CMAX) |=>
            (cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) + 1'b1));
   end
endmodule

// File: rtl/slt_decide.sv
module slt_decide
   import slt_pkg::*;
#(
   parameter int AW     = 32,
   parameter int IW     = 4,
   parameter int TAG_W  = 23,
   parameter int REG_LG = 10,
   parameter int RC_IW  = 6
) (
   input  logic             acc_valid,
   input  logic             acc_hit,
   input  logic [SUB_W-1:0] sub,
   input  logic [TAG_W-1:0] cur_tag,
   input  logic [IW-1:0]    dt_idx,
   input  logic             e_valid,
   input  logic [TAG_W-1:0] e_tag,
   input  logic             e_sz,
   input  logic [VC_W-1:0]  e_vc,
   input  logic [SUBS-1:0]  e_mask,
   input  logic             e_sr,
   input  logic [SUB_W-1:0] e_fi,
   input  logic             cnt_msb,
   output logic             wr_en,
   output logic [TAG_W-1:0] n_tag,
   output logic             n_sz,
   output logic [VC_W-1:0]  n_vc,
   output logic [SUBS-1:0]  n_mask,
   output logic             n_sr,
   output logic [SUB_W-1:0] n_fi,
   output logic             inc,
   output logic             dec,
   output logic [RC_IW-1:0] ev_region,
   output logic             fetch_req,
   output logic             fetch_big
);
   logic            dt_hit, fresh, small_reuse, big_reuse;
   logic [SUBS-1:0] sub_oh;
   logic [AW-1:0]   ev_addr;

   assign dt_hit  = e_valid && (e_tag == cur_tag);
   assign sub_oh  = SUBS'(1) << sub;
   assign fresh   = !e_mask[sub];
   assign small_reuse = !acc_hit && (e_sz == FETCH_LINE) && (sub != e_fi);
   assign big_reuse   = (e_sz == FETCH_VLINE) && fresh && (e_vc == VC_FULL - 1'b1);
   assign ev_addr   = {e_tag, dt_idx, {VLINE_LG{1'b0}}};
   assign ev_region = ev_addr[REG_LG +: RC_IW];

   always_comb begin
      wr_en     = 1'b0;
      n_tag     = cur_tag;
      n_sz      = cnt_msb;
      n_vc      = VC_W'(1);
      n_mask    = sub_oh;
      n_sr      = 1'b0;
      n_fi      = sub;
      inc       = 1'b0;
      dec       = 1'b0;
      fetch_req = 1'b0;
      fetch_big = cnt_msb;
      if (acc_valid) begin
         fetch_req = !acc_hit;
         if (dt_hit) begin
            wr_en  = 1'b1;
            n_tag  = e_tag;
            n_sz   = e_sz;
            n_fi   = e_fi;
            n_mask = e_mask | sub_oh;
            n_vc   = (fresh && e_vc != VC_FULL) ? VC_W'(e_vc + 1'b1) : e_vc;
            inc    = !e_sr && (small_reuse || big_reuse);
            n_sr   = e_sr || inc;
         end else if (!acc_hit) begin
            wr_en = 1'b1;
            dec   = e_valid && !e_sr;
         end
      end
   end
endmodule

// File: rtl/slt_fetch_sel.sv
module slt_fetch_sel
   import slt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DT_DEPTH  = 16,
   parameter int RC_DEPTH  = 64,
   parameter int REGION_LG = 10,
   parameter int SCTR_W    = 4,
   localparam int DT_IW    = $clog2(DT_DEPTH),
   localparam int RC_IW    = $clog2(RC_DEPTH),
   localparam int TAG_W    = ADDR_W - VLINE_LG - DT_IW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_hit,
   output logic              fetch_vld,
   output logic              fetch_big,
   output logic              sctr_inc,
   output logic              sctr_dec,
   output logic [RC_IW-1:0]  sctr_region
);
   if (REGION_LG <= VLINE_LG || ADDR_W < REGION_LG + RC_IW || TAG_W < 1) begin : g_bad_geom
      $error("slt_fetch_sel: address geometry inconsistent");
   end

   logic [SUB_W-1:0] sub;
   logic [DT_IW-1:0] dt_idx;
   logic [TAG_W-1:0] cur_tag;
   logic [RC_IW-1:0] cur_region;
   logic             unused_low;

   assign sub        = acc_addr[LINE_LG +: SUB_W];
   assign dt_idx     = acc_addr[VLINE_LG +: DT_IW];
   assign cur_tag    = acc_addr[ADDR_W-1 -: TAG_W];
   assign cur_region = acc_addr[REGION_LG +: RC_IW];
   assign unused_low = ^acc_addr[LINE_LG-1:0];

   logic             e_valid, e_sz, e_sr;
   logic [TAG_W-1:0] e_tag;
   logic [VC_W-1:0]  e_vc;
   logic [SUBS-1:0]  e_mask;
   logic [SUB_W-1:0] e_fi;
   logic             wr_en, n_sz, n_sr;
   logic [TAG_W-1:0] n_tag;
   logic [VC_W-1:0]  n_vc;
   logic [SUBS-1:0]  n_mask;
   logic [SUB_W-1:0] n_fi;
   logic             cnt_msb, inc, dec, fetch_req, fetch_pick;
   logic [RC_IW-1:0] ev_region, upd_idx;

   slt_dtab #(.DEPTH(DT_DEPTH), .IW(DT_IW), .TAG_W(TAG_W)) u_dtab (
      .clk(clk), .rst_n(rst_n), .idx(dt_idx),
      .rd_valid(e_valid), .rd_tag(e_tag), .rd_sz(e_sz), .rd_vc(e_vc),
      .rd_mask(e_mask), .rd_sr(e_sr), .rd_fi(e_fi),
      .wr_en(wr_en), .wr_tag(n_tag), .wr_sz(n_sz), .wr_vc(n_vc),
      .wr_mask(n_mask), .wr_sr(n_sr), .wr_fi(n_fi)
   );

   slt_decide #(.AW(ADDR_W), .IW(DT_IW), .TAG_W(TAG_W),
                .REG_LG(REGION_LG), .RC_IW(RC_IW)) u_dec (
      .acc_valid(acc_valid), .acc_hit(acc_hit), .sub(sub), .cur_tag(cur_tag),
      .dt_idx(dt_idx), .e_valid(e_valid), .e_tag(e_tag), .e_sz(e_sz),
      .e_vc(e_vc), .e_mask(e_mask), .e_sr(e_sr), .e_fi(e_fi),
      .cnt_msb(cnt_msb), .wr_en(wr_en), .n_tag(n_tag), .n_sz(n_sz),
      .n_vc(n_vc), .n_mask(n_mask), .n_sr(n_sr), .n_fi(n_fi),
      .inc(inc), .dec(dec), .ev_region(ev_region),
      .fetch_req(fetch_req), .fetch_big(fetch_pick)
   );

   assign upd_idx = dec ? ev_region : cur_region;

   slt_rctr #(.DEPTH(RC_DEPTH), .IW(RC_IW), .W(SCTR_W)) u_rctr (
      .clk(clk), .rst_n(rst_n), .rd_idx(cur_region), .rd_msb(cnt_msb),
      .inc_en(inc), .dec_en(dec), .upd_idx(upd_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_vld   <= 1'b0;
         fetch_big   <= 1'b0;
         sctr_inc    <= 1'b0;
         sctr_dec    <= 1'b0;
         sctr_region <= '0;
      end else begin
         fetch_vld   <= fetch_req;
         fetch_big   <= fetch_req && fetch_pick;
         sctr_inc    <= inc;
         sctr_dec    <= dec;
         sctr_region <= upd_idx;
      end
   end

   a_r2_fetch_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld |-> $past(acc_valid && !acc_hit));
   a_r2_no_fetch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |=> !fetch_vld);
   a_r7_dec_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      sctr_dec |-> $past(acc_valid && !acc_hit));
   a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      !(sctr_inc && sctr_dec));
   a_r3_inc_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      sctr_inc |-> $past(acc_valid));
endmodule

// File: tb/sim_slt_fetch_sel.sv
`timescale 1ns/1ps
module sim_slt_fetch_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_hit = 1'b0;
   logic        fetch_vld, fetch_big, sctr_inc, sctr_dec;
   logic [5:0]  sctr_region;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   slt_fetch_sel u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_hit(acc_hit), .fetch_vld(fetch_vld), .fetch_big(fetch_big),
      .sctr_inc(sctr_inc), .sctr_dec(sctr_dec), .sctr_region(sctr_region)
   );

   // Reference model built from the requirements
   logic        mv    [16];
   logic [26:0] mvl   [16];
   logic        msz   [16];
   logic [1:0]  mfi   [16];
   logic [1:0]  mvc   [16];
   logic [3:0]  mmask [16];
   logic        msr   [16];
   int          ctr   [64];

   task automatic chk(input string req, input string scen,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] act=%0h exp=%0h", req, scen, act, exp);
      end
   endtask

   function automatic logic [31:0] va(input int region, input int vl, input int sb);
      return 32'((region << 10) | (vl << 5) | (sb << 3));
   endfunction

   task automatic step(input logic [31:0] a, input logic h, input string scen);
      logic [1:0]  sb  = a[4:3];
      logic [26:0] vl  = a[31:5];
      int          ix  = int'(a[8:5]);
      int          rg  = int'(a[15:10]);
      logic        e_fv = !h;
      logic        e_big = (ctr[rg] >= 8);
      logic        e_inc = 1'b0;
      logic        e_dec = 1'b0;
      int          e_rg = rg;
      if (mv[ix] && mvl[ix] == vl) begin
         logic fresh = !mmask[ix][sb];
         logic sm = !h && !msz[ix] && (sb != mfi[ix]);
         logic bg = msz[ix] && fresh && (mvc[ix] == 2'd2);
         e_inc = !msr[ix] && (sm || bg);
         mmask[ix] = mmask[ix] | (4'b1 << sb);
         if (fresh && mvc[ix] != 2'd3) mvc[ix] = mvc[ix] + 2'd1;
         msr[ix] = msr[ix] | e_inc;
      end else if (!h) begin
         e_dec = mv[ix] && !msr[ix];
         if (e_dec) e_rg = int'(mvl[ix][10:5]);
         mv[ix] = 1'b1; mvl[ix] = vl; msz[ix] = e_big; mfi[ix] = sb;
         mvc[ix] = 2'd1; mmask[ix] = 4'b1 << sb; msr[ix] = 1'b0;
      end
      if (e_inc && ctr[e_rg] < 15) ctr[e_rg]++;
      if (e_dec && ctr[e_rg] > 0) ctr[e_rg]--;
      acc_addr = a; acc_hit = h; acc_valid = 1'b1;
      @(negedge clk);
      chk("R2", scen, 32'(fetch_vld), 32'(e_fv));
      if (e_fv) chk("R5", scen, 32'(fetch_big), 32'(e_big));
      chk("R3 R4", scen, 32'(sctr_inc), 32'(e_inc));
      chk("R7", scen, 32'(sctr_dec), 32'(e_dec));
      if (e_inc || e_dec) chk("R10", scen, 32'(sctr_region), 32'(e_rg));
      acc_valid = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
   end

   initial begin
      logic [31:0] lf;
      for (int i = 0; i < 16; i++) begin
         mv[i] = 1'b0; mvl[i] = '0; msz[i] = 1'b0; mfi[i] = '0;
         mvc[i] = '0; mmask[i] = '0; msr[i] = 1'b0;
      end
      for (int i = 0; i < 64; i++) ctr[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset", 32'(fetch_vld), 0);
      chk("R1", "reset", 32'(fetch_big), 0);
      chk("R1", "reset", 32'(sctr_inc), 0);
      chk("R1", "reset", 32'(sctr_dec), 0);
      // idle cycle: nothing issued
      @(negedge clk);
      chk("R2", "idle", 32'(fetch_vld), 0);

      // R1 + R6 + R3: first miss small, neighbour miss raises
      for (int v = 0; v < 8; v++) begin
         step(va(5, v, 0), 1'b0, "R3_small_reuse");
         step(va(5, v, 2), 1'b0, "R3_small_reuse");
         step(va(5, v, 2), 1'b0, "R3_once_per_entry");
      end
      // R5: counter now at 8, so new lines fetch large
      step(va(5, 9, 1), 1'b0, "R5_large_pick");
      step(va(5, 9, 1), 1'b1, "R4_same_sub");
      step(va(5, 9, 3), 1'b1, "R4_second");
      step(va(5, 9, 0), 1'b0, "R4_third_raises");
      step(va(5, 9, 2), 1'b1, "R4_fourth_quiet");
      // R9: cache hit with table miss allocates nothing
      step(va(5, 12, 0), 1'b1, "R9_hit_no_alloc");
      step(va(5, 12, 1), 1'b0, "R9_then_miss");
      // R8: push to ceiling
      for (int v = 16; v < 32; v++) begin
         step(va(5, v, 0), 1'b0, "R8_fill");
         step(va(5, v, 1), 1'b0, "R8_fill");
         step(va(5, v, 2), 1'b0, "R8_fill");
      end
      // R7 + R8: ping-pong evictions of unused entries
      for (int k = 0; k < 22; k++)
         step(va(5, (k % 2) ? 19 : 3, 0), 1'b0, "R7_evict_drain");
      // R8 floor, then eight raises flip to large
      for (int v = 0; v < 9; v++) begin
         step(va(7, v, 1), 1'b0, "R8_floor_rise");
         step(va(7, v, 0), 1'b0, "R8_floor_rise");
      end
      // aliasing region (same counter index, different tag)
      step(va(69, 3, 0), 1'b0, "R10_alias_evict");
      step(va(5, 3, 0), 1'b0, "R10_alias_evict");

      // pseudo-random sweep over aliasing addresses
      lf = 32'hACE1_1234;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a = va(int'(lf[1:0]) + (lf[2] ? 64 : 0), int'(lf[7:3]), int'(lf[9:8]));
         step(a, lf[12:10] < 3'd3, "sweep");
      end
      repeat (2) @(negedge clk);
      chk("R2", "final_idle", 32'(fetch_vld), 0);
      summary();
   end
endmodule